// File: doc/BRIEF.md
# Frequency Source Selection Controller

This block owns the frequency-related control bytes of a clock synthesizer and decides, every cycle, which 5-bit ratio code and which N/M divider pair the synthesizer is told to use. Three sources compete: the board strap pins, captured while power-good is still low; a software ratio code written over the serial register interface; and a direct N/M programming path. The block resolves them under fixed priorities and applies a plausibility rule to the N/M pair.

A watchdog elsewhere can lock the block into recovery mode. While it is locked, register writes that would move the frequency are dropped. The outputs then follow either the latched straps or recovery N/M values supplied by the watchdog. Each time the resolved selection changes, a single-cycle pulse is raised. Other logic uses it to start a reload or a system reset.

Top module: `freq_src_ctrl`

## Requirements
- R1: While `pwrgd_n` is low the strap code is captured on every clock edge; while it is high the captured value is held. Byte 1 reads the held code in bits 7:3 (strap bit 4 in bit 7, strap bit 0 in bit 3), with bits 2:0 reading 0.
- R2: Byte 0 holds the software ratio code as SEL4 in bit 2, SEL3 in bit 1, SEL2 in bit 6, SEL1 in bit 5 and SEL0 in bit 4. The override flag is in bit 3 and two spread bits are in bits 7 and 0. The byte reads back as written.
- R3: Outside recovery mode, `ratio_code` equals the held strap code when the override flag is 0, and the SEL code when it is 1.
- R4: Byte 13 holds N (8 bits). Byte 14 holds M in bits 6:0 and the programmable-enable flag in bit 7. Outside recovery, `prog_mode` follows that flag, and the ratio code is unaffected by it.
- R5: A write to byte 13 or byte 14 forms a candidate pair from the new value and the other stored register. The effective `eff_n`/`eff_m` take this pair when N is strictly greater than M.
- R6: A candidate with N less than or equal to M leaves `eff_n`/`eff_m` unchanged, although the written byte still reads back.
- R7: While `recov_lock` is high, writes to bytes 13 and 14 and to bits 6:1 of byte 0 are ignored. The spread bits 7 and 0 of byte 0 still accept writes.
- R8: While locked with `recov_sel` = 1, `eff_n`/`eff_m` show `recov_n`/`recov_m` and `prog_mode` is 1. While locked with `recov_sel` = 0, `ratio_code` shows the held straps and `prog_mode` is 0. Releasing the lock restores the software selection.
- R9: The outputs are registered one cycle after their sources. `freq_chg` is high for exactly the cycle in which `ratio_code`, `eff_n`, `eff_m` or `prog_mode` takes a new value, and low otherwise.
- R10: Reset clears every writable bit, the held strap code and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register byte address for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Register byte address for reads |
| rd_data | output | 8 | Combinational read data |
| strap_code | input | 5 | Board strap pins |
| pwrgd_n | input | 1 | Active-low power-good; straps are tracked while low |
| recov_lock | input | 1 | Recovery-mode lock from the watchdog |
| recov_sel | input | 1 | Recovery source: 1 = recovery N/M, 0 = straps |
| recov_n | input | 8 | Recovery N value |
| recov_m | input | 7 | Recovery M value |
| ratio_code | output | 5 | Active ratio / gear code |
| eff_n | output | 8 | Active N value |
| eff_m | output | 7 | Active M value |
| prog_mode | output | 1 | Direct N/M programming active |
| freq_chg | output | 1 | One-cycle pulse on any change of the selection |

## Verification
The assertions assume that `recov_n`, `recov_m` and `recov_sel` change only while `recov_lock` is low, or while it is being raised. A change of those inputs while the lock is held would correctly produce a pulse, but the lock-freeze checks would not expect it. The stimulus therefore sets the recovery values before raising the lock, and changes only `recov_sel` during a held lock, as a deliberate source switch. Writes are driven one at a time, away from the clock edge. Outputs are sampled one registered cycle after each write or lock change.

// File: rtl/freq_src_ctrl.sv
module freq_src_ctrl #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int CTL_ADDR   = 0,
  parameter int STRAP_ADDR = 1,
  parameter int N_ADDR     = 13,
  parameter int M_ADDR     = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [4:0]          strap_code,
  input  logic                pwrgd_n,
  input  logic                recov_lock,
  input  logic                recov_sel,
  input  logic [DATA_W-1:0]   recov_n,
  input  logic [DATA_W-2:0]   recov_m,
  output logic [4:0]          ratio_code,
  output logic [DATA_W-1:0]   eff_n,
  output logic [DATA_W-2:0]   eff_m,
  output logic                prog_mode,
  output logic                freq_chg
);
  localparam int CODE_W = 5;
  localparam int N_W    = DATA_W;
  localparam int M_W    = DATA_W - 1;
  localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_STRAP = ADDR_W'(STRAP_ADDR);
  localparam logic [ADDR_W-1:0] A_N     = ADDR_W'(N_ADDR);
  localparam logic [ADDR_W-1:0] A_M     = ADDR_W'(M_ADDR);

  logic [CODE_W-1:0] strap_q;
  logic [DATA_W-1:0] ctl_q;
  logic [N_W-1:0]    n_q;
  logic [DATA_W-1:0] m_q;
  logic [N_W-1:0]    pair_n_q;
  logic [M_W-1:0]    pair_m_q;

  wire [CODE_W-1:0] sel_code = {ctl_q[2], ctl_q[1], ctl_q[6], ctl_q[5], ctl_q[4]};
  wire              ovr      = ctl_q[3];
  wire              prog_en  = m_q[DATA_W-1];
  wire              wr_ctl   = wr_en && (wr_addr == A_CTL);
  wire              wr_n     = wr_en && (wr_addr == A_N) && !recov_lock;
  wire              wr_m     = wr_en && (wr_addr == A_M) && !recov_lock;
  wire [M_W-1:0]    new_m    = wr_data[M_W-1:0];
  wire              n_ok     = wr_data > {1'b0, m_q[M_W-1:0]};
  wire              m_ok     = n_q > {1'b0, new_m};

  // Strap capture while power-good is still deasserted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        strap_q <= '0;
    else if (!pwrgd_n) strap_q <= strap_code;
  end

  // Control byte: spread bits always writable, frequency bits frozen by lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      ctl_q[DATA_W-1] <= wr_data[DATA_W-1];
      ctl_q[0]        <= wr_data[0];
      if (!recov_lock) ctl_q[DATA_W-2:1] <= wr_data[DATA_W-2:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q      <= '0;
      m_q      <= '0;
      pair_n_q <= '0;
      pair_m_q <= '0;
    end else if (wr_n) begin
      n_q <= wr_data;
      if (n_ok) begin
        pair_n_q <= wr_data;
        pair_m_q <= m_q[M_W-1:0];
      end
    end else if (wr_m) begin
      m_q <= wr_data;
      if (m_ok) begin
        pair_n_q <= n_q;
        pair_m_q <= new_m;
      end
    end
  end

  logic [CODE_W-1:0] nxt_code;
  logic [N_W-1:0]    nxt_n;
  logic [M_W-1:0]    nxt_m;
  logic              nxt_prog;

  always_comb begin
    nxt_code = ((recov_lock && !recov_sel) || !ovr) ? strap_q : sel_code;
    nxt_prog = recov_lock ? recov_sel : prog_en;
    nxt_n    = (recov_lock && recov_sel) ? recov_n : pair_n_q;
    nxt_m    = (recov_lock && recov_sel) ? recov_m : pair_m_q;
  end

  wire differs = (nxt_code != ratio_code) || (nxt_n != eff_n) ||
                 (nxt_m != eff_m) || (nxt_prog != prog_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_code <= '0;
      eff_n      <= '0;
      eff_m      <= '0;
      prog_mode  <= 1'b0;
      freq_chg   <= 1'b0;
    end else begin
      ratio_code <= nxt_code;
      eff_n      <= nxt_n;
      eff_m      <= nxt_m;
      prog_mode  <= nxt_prog;
      freq_chg   <= differs;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTL:   rd_data = ctl_q;
      A_STRAP: rd_data = {strap_q, {(DATA_W-CODE_W){1'b0}}};
      A_N:     rd_data = n_q;
      A_M:     rd_data = m_q;
      default: rd_data = '0;
    endcase
  end

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwrgd_n) |-> $stable(strap_q));

  // R6
  pair_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_n_q > {1'b0, pair_m_q}) || (pair_n_q == '0 && pair_m_q == '0));

  // R7
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(recov_lock) |-> ($stable(n_q) && $stable(m_q) && $stable(ctl_q[DATA_W-2:1])));

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_chg |-> (ratio_code != $past(ratio_code) || eff_n != $past(eff_n) ||
                  eff_m != $past(eff_m) || prog_mode != $past(prog_mode)));

  // R9
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_chg |-> ($stable(ratio_code) && $stable(eff_n) && $stable(eff_m) && $stable(prog_mode)));

  // R8
  recov_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(recov_lock) |-> (prog_mode == $past(recov_sel)));
endmodule

// File: tb/freq_src_ctrl_tb_top.sv
module freq_src_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [4:0] strap_code = 5'b10110;
  logic       pwrgd_n = 1'b0;
  logic       recov_lock = 1'b0;
  logic       recov_sel = 1'b0;
  logic [7:0] recov_n = '0;
  logic [6:0] recov_m = '0;
  logic [4:0] ratio_code;
  logic [7:0] eff_n;
  logic [6:0] eff_m;
  logic       prog_mode;
  logic       freq_chg;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  freq_src_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .strap_code(strap_code), .pwrgd_n(pwrgd_n),
    .recov_lock(recov_lock), .recov_sel(recov_sel), .recov_n(recov_n), .recov_m(recov_m),
    .ratio_code(ratio_code), .eff_n(eff_n), .eff_m(eff_m), .prog_mode(prog_mode),
    .freq_chg(freq_chg)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic outs(input string req, input int c, input int n, input int m,
                      input int p, input int pulse);
    chk({req, " ratio_code"}, ratio_code, c);
    chk({req, " eff_n"}, eff_n, n);
    chk({req, " eff_m"}, eff_m, m);
    chk({req, " prog_mode"}, prog_mode, p);
    chk({req, " freq_chg"}, freq_chg, pulse);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 outs("R10 reset", 0, 0, 0, 0, 0);
    rd(5'd0, d);  chk("R10 byte0", d, 0);
    rd(5'd13, d); chk("R10 byte13", d, 0);
    rd(5'd14, d); chk("R10 byte14", d, 0);
    @(negedge clk) rst_n = 1'b1;
    step; step;
    outs("R1 strap capture", 5'b10110, 0, 0, 0, 1);
    step;
    chk("R9 pulse one cycle", freq_chg, 0);
  endtask

  task automatic t_strap_hold;
    logic [7:0] d;
    @(negedge clk);
    pwrgd_n = 1'b1; strap_code = 5'b01001;
    repeat (4) step;
    chk("R1 strap held", ratio_code, 5'b10110);
    chk("R1 no pulse on hold", freq_chg, 0);
    rd(5'd1, d); chk("R1 byte1 readback", d, 8'hB0);
  endtask

  task automatic t_override;
    logic [7:0] d;
    wr(5'd0, 8'h5A);
    step;
    outs("R3 override to SEL", 5'b01101, 0, 0, 0, 1);
    rd(5'd0, d); chk("R2 byte0 readback", d, 8'h5A);
  endtask

  task automatic t_prog;
    logic [7:0] d;
    wr(5'd13, 8'd150); step;
    outs("R5 N write loads", 5'b01101, 150, 0, 0, 1);
    wr(5'd14, 8'h80 | 8'd45); step;
    outs("R4 prog enable with M", 5'b01101, 150, 45, 1, 1);
    wr(5'd13, 8'd40); step;
    outs("R6 N below M ignored", 5'b01101, 150, 45, 1, 0);
    rd(5'd13, d); chk("R6 N readback", d, 40);
    wr(5'd14, 8'h80 | 8'd30); step;
    outs("R5 M write pairs stored N", 5'b01101, 40, 30, 1, 1);
    wr(5'd13, 8'd30); step;
    outs("R6 N equal M ignored", 5'b01101, 40, 30, 1, 0);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    @(negedge clk);
    recov_n = 8'd200; recov_m = 7'd93; recov_sel = 1'b1; recov_lock = 1'b1;
    step;
    outs("R8 recovery N/M", 5'b01101, 200, 93, 1, 1);
    step;
    chk("R9 pulse ends", freq_chg, 0);
    wr(5'd0, 8'hFF); step;
    outs("R7 byte0 locked", 5'b01101, 200, 93, 1, 0);
    rd(5'd0, d); chk("R7 spread bits written", d, 8'hDB);
    wr(5'd13, 8'd250); step;
    rd(5'd13, d); chk("R7 N write dropped", d, 30);
    wr(5'd14, 8'h05); step;
    rd(5'd14, d); chk("R7 M write dropped", d, 8'h80 | 8'd30);
    @(negedge clk) recov_sel = 1'b0;
    step;
    outs("R8 recovery to straps", 5'b10110, 40, 30, 0, 1);
    @(negedge clk) recov_lock = 1'b0;
    step;
    outs("R8 lock release", 5'b01101, 40, 30, 1, 1);
  endtask

  task automatic t_prog_off;
    wr(5'd14, 8'h1E); step;
    outs("R4 prog disable", 5'b01101, 40, 30, 0, 1);
    wr(5'd0, 8'h52); step;
    outs("R3 override cleared", 5'b10110, 40, 30, 0, 1);
    step;
    chk("R9 quiet", freq_chg, 0);
  endtask

  initial begin
    t_reset();
    t_strap_hold();
    t_override();
    t_prog();
    t_lock();
    t_prog_off();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule